// File: doc/BRIEF.md
# Gated Token Ring Word Selector

This block steps a single token around a ring of stages and drives a one-hot word-select vector, one bit for each stage. The stages are split into equal groups. Each group has its own stage-clock enable, so a stage only captures while its group is enabled. An enable is on only while the token sits inside its group, or when the token is one step away from entering it. The other groups stay idle. Every stage captures on both the rising and the falling edge of the clock. The token therefore moves one stage per clock edge, and the clock can run at half the token rate.

Each group holds its enable in a hold element that behaves like a C-element. Its "set" input is the last stage of the group before it, and its "clear" input is the group's own last stage. The element moves to a new value only when the two inputs agree: the token is arriving and is not leaving, or the token is leaving and is not arriving. In every other case it keeps its value. The ring's own outputs drive the enables, and no separate address decoder is used. The gating is modelled as registered enables that feed the stage registers of each group. No physical clock-gating cell is used.

The block has no data path, so it has no valid/ready interface and applies no back-pressure. All pins are plain level controls and status outputs.

Top module: `gated_token_ring`

## Requirements
- R1: After reset, exactly one bit of `word_sel` is high on every clock edge.
- R2: While `run_en` is high, the token moves from stage i to stage i+1 on every rising edge and on every falling edge of `clk`. From the last stage it wraps to stage 0. Bit i of `word_sel` is stage i.
- R3: While `run_en` is low, `word_sel` and `grp_en` keep their values across clock edges.
- R4: Reset must be held high across at least one rising edge and one falling edge. After that, `word_sel` has only bit 0 set and `grp_en` has only bit 0 set, whatever the value of `run_en`. Reset is synchronous.
- R5: Group g contains stages g*GROUP_SIZE to g*GROUP_SIZE+GROUP_SIZE-1. Bit g of `grp_en` is high whenever the token is in group g.
- R6: When the token is in the last stage of group g, bit (g+1) mod NUM_GROUPS of `grp_en` is also high. That group is therefore enabled one edge before the token enters it.
- R7: Every other bit of `grp_en` is low. When the token leaves a group, that group's enable falls on the same edge that moves the token out, so at most two bits are ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The stages capture on both edges. |
| rst | input | 1 | Synchronous reset, active high. Must be held across both clock edges. |
| run_en | input | 1 | Global enable. When low, the ring and all group enables hold. |
| word_sel | output | NUM_STAGES | One-hot word select. Bit i is high while the token is in stage i. |
| grp_en | output | NUM_STAGES/GROUP_SIZE | Per-group stage-clock enable. |

## Verification
A bad hold-element state shows up at the ports within one clock edge. If an enable stays on too long, an extra bit appears in `grp_en`. If an enable is missing, the token stalls in the last stage of the group before it. The next `word_sel` sample then shows the token still there, or duplicated, or gone. A wrong stage register shows up as a `word_sel` pattern that is not one-hot, or as a token in the wrong position, on the edge right after the fault. The bench therefore compares both outputs against an edge-by-edge position model on every edge, including the wrap from the last stage to stage 0 and stretches with `run_en` low.

// File: rtl/token_ring_pkg.sv
package token_ring_pkg;
  localparam int unsigned DEF_STAGES     = 8;
  localparam int unsigned DEF_GROUP_SIZE = 2;

  // Index of the group that feeds group g around the ring.
  function automatic int unsigned feeder_group(input int unsigned g, input int unsigned groups);
    return (g + groups - 1) % groups;
  endfunction
endpackage

// File: rtl/dual_edge_reg.sv
// Register that captures on both clock edges, built from one rising-edge
// and one falling-edge half. The stored value is the XOR of the two halves.
module dual_edge_reg #(
  parameter int unsigned       W    = 1,
  parameter logic [W-1:0]      INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] rise_half;
  logic [W-1:0] fall_half;
  logic [W-1:0] target;

  always_comb begin
    target = en ? d : q;
  end

  always_ff @(posedge clk) begin
    if (rst) rise_half <= INIT;
    else     rise_half <= target ^ fall_half;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_half <= '0;
    else     fall_half <= target ^ rise_half;
  end

  assign q = rise_half ^ fall_half;
endmodule

// File: rtl/hold_gate.sv
// C-element style enable holder for one group. It goes high when the token
// is arriving and not leaving, goes low when the token is leaving and not
// arriving, and holds otherwise. The gate also opens combinationally while
// the token waits in the feeder stage, so that the group captures on the
// entering edge.
module hold_gate #(
  parameter logic START_ON = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic arrive_i,
  input  logic depart_i,
  output logic gate_o
);
  logic held;
  logic held_next;

  always_comb begin
    if (arrive_i && !depart_i)      held_next = 1'b1;
    else if (!arrive_i && depart_i) held_next = 1'b0;
    else                            held_next = held;
  end

  dual_edge_reg #(.W(1), .INIT(START_ON)) u_state (
    .clk (clk),
    .rst (rst),
    .en  (run_en),
    .d   (held_next),
    .q   (held)
  );

  assign gate_o = held | arrive_i;
endmodule

// File: rtl/ring_segment.sv
// One group of ring stages with its own gated enable.
module ring_segment #(
  parameter int unsigned SIZE  = 2,
  parameter bit          FIRST = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic            token_in,
  output logic [SIZE-1:0] stages,
  output logic            gate_o
);
  localparam logic [SIZE-1:0] STAGE_INIT = FIRST ? SIZE'(1) : '0;

  logic [SIZE-1:0] shift_in;
  logic            cap_en;

  generate
    if (SIZE == 1) begin : g_single
      assign shift_in = token_in;
    end else begin : g_multi
      assign shift_in = {stages[SIZE-2:0], token_in};
    end
  endgenerate

  hold_gate #(.START_ON(FIRST)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .arrive_i (token_in),
    .depart_i (stages[SIZE-1]),
    .gate_o   (gate_o)
  );

  assign cap_en = run_en & gate_o;

  dual_edge_reg #(.W(SIZE), .INIT(STAGE_INIT)) u_stages (
    .clk (clk),
    .rst (rst),
    .en  (cap_en),
    .d   (shift_in),
    .q   (stages)
  );
endmodule

// File: rtl/gated_token_ring.sv
module gated_token_ring
  import token_ring_pkg::*;
#(
  parameter int unsigned NUM_STAGES = DEF_STAGES,
  parameter int unsigned GROUP_SIZE = DEF_GROUP_SIZE
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 run_en,
  output logic [NUM_STAGES-1:0]                word_sel,
  output logic [NUM_STAGES/GROUP_SIZE-1:0]     grp_en
);
  localparam int unsigned NUM_GROUPS = NUM_STAGES / GROUP_SIZE;

  logic [NUM_GROUPS-1:0] last_of;

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_seg
      localparam int unsigned FEED = feeder_group(g, NUM_GROUPS);
      logic [GROUP_SIZE-1:0] seg_q;

      ring_segment #(.SIZE(GROUP_SIZE), .FIRST(g == 0)) u_seg (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .token_in (last_of[FEED]),
        .stages   (seg_q),
        .gate_o   (grp_en[g])
      );

      assign last_of[g] = seg_q[GROUP_SIZE-1];
      assign word_sel[g*GROUP_SIZE +: GROUP_SIZE] = seg_q;
    end
  endgenerate

  // Stage mask spread from the group enables, used by the checks below.
  logic [NUM_STAGES-1:0] stage_open;
  always_comb begin
    for (int i = 0; i < NUM_STAGES; i++) stage_open[i] = grp_en[i / GROUP_SIZE];
  end

  // R1: one token on both edges
  a_r1_one_hot_rise: assert property (@(posedge clk) disable iff (rst)
    $countones(word_sel) == 1);
  a_r1_one_hot_fall: assert property (@(negedge clk) disable iff (rst)
    $countones(word_sel) == 1);
  // R5: the group holding the token is enabled
  a_r5_token_group_open: assert property (@(posedge clk) disable iff (rst)
    (word_sel & ~stage_open) == '0);
  // R7: at most two group enables, never none
  a_r7_enable_count: assert property (@(posedge clk) disable iff (rst)
    ($countones(grp_en) >= 1) && ($countones(grp_en) <= 2));
endmodule

// File: tb/tb_gated_token_ring.sv
module tb_gated_token_ring;
  localparam int N  = 8;
  localparam int GS = 2;
  localparam int G  = N / GS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [N-1:0] word_sel;
  logic [G-1:0] grp_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int pos = 0;

  gated_token_ring #(.NUM_STAGES(N), .GROUP_SIZE(GS)) dut (
    .clk(clk), .rst(rst), .run_en(run_en), .word_sel(word_sel), .grp_en(grp_en)
  );

  always #10 clk = ~clk;

  // {run_en, expected position after the next edge}
  localparam logic [3:0] VEC [16] = '{
    4'h9, 4'hA, 4'hB, 4'h3, 4'h3, 4'hC, 4'hD, 4'hE,
    4'hF, 4'h8, 4'h0, 4'h9, 4'hA, 4'h2, 4'hB, 4'hC
  };

  function automatic logic [G-1:0] exp_grp(input int p);
    logic [G-1:0] v;
    v = '0;
    v[p / GS] = 1'b1;
    if ((p % GS) == GS - 1) v[((p / GS) + 1) % G] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic e);
    run_en = e;
    @(posedge clk or negedge clk);
    #3;
  endtask

  task automatic check_state(input string req);
    chk({req, " word_sel"}, 32'(word_sel), 32'(1) << pos);
    chk({req, " grp_en (R5 R6 R7)"}, 32'(grp_en), 32'(exp_grp(pos)));
    chk("R1 one-hot", 32'($countones(word_sel)), 32'd1);
  endtask

  initial begin
    // R4: reset with run_en low, over several edges
    for (int i = 0; i < 4; i++) step(1'b0);
    pos = 0;
    chk("R4 reset word_sel", 32'(word_sel), 32'd1);
    chk("R4 reset grp_en", 32'(grp_en), 32'd1);
    rst = 1'b0;

    // Table walk: R2 moves, R3 holds
    for (int k = 0; k < 16; k++) begin
      step(VEC[k][3]);
      pos = int'(VEC[k][2:0]);
      check_state(VEC[k][3] ? "R2" : "R3");
    end

    // R4: reset mid-run with run_en high
    rst = 1'b1;
    step(1'b1);
    step(1'b1);
    rst = 1'b0;
    pos = 0;
    chk("R4 mid-run word_sel", 32'(word_sel), 32'd1);
    chk("R4 mid-run grp_en", 32'(grp_en), 32'd1);

    // R2: long run with wrap on every lap
    for (int k = 0; k < 60; k++) begin
      step(1'b1);
      pos = (pos + 1) % N;
      check_state("R2 long run");
    end

    // R6 + R3: park in the last stage of a group and hold
    while (pos != 3) begin
      step(1'b1);
      pos = (pos + 1) % N;
    end
    for (int k = 0; k < 5; k++) begin
      step(1'b0);
      check_state("R3 R6 parked");
    end

    // R6: park at the last stage, where the next group wraps to group 0
    while (pos != N - 1) begin
      step(1'b1);
      pos = (pos + 1) % N;
    end
    check_state("R6 wrap");
    chk("R6 wrap grp_en", 32'(grp_en), 32'h9);
    step(1'b1);
    pos = 0;
    check_state("R7 after leaving");
    chk("R7 grp_en", 32'(grp_en), 32'h1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule